// File: doc/BRIEF.md
# Serial Slave Bit Engine with Transfer Pause

This block is the bit-level edge of a serial memory slave. It watches four pins driven by an external master: a serial clock, an active-low select, a serial data input and an active-low pause request. All four are brought into the local system clock through two-flop synchronisers, and clock edges are found there. The system clock must therefore run at least four times faster than the serial clock. Incoming bits are packed into bytes, most significant bit first. Outgoing bytes are shifted onto a serial output that has a separate enable, so a pad can tri-state it.

A command layer sits behind the block. It receives a one-cycle strobe with each completed byte, a pulse when a frame opens, and a pulse when a frame closes that says whether the frame ended on a whole byte. In return it supplies the next byte to send, an output-enable request, and a one-cycle drop request. The drop request silences the block until the select line falls again. A pause request freezes the serial sequence where it stands without restarting it. The pause is entered and left only while the serial clock is low.

Top module: `spi_hold_front`

## Requirements
- R1: After reset the output enable, byte strobe, frame pulses and byte index are all 0.
- R2: While `cs_n` is high, serial clock edges and `si` have no effect: no byte strobe appears and `so_oe` stays 0.
- R3: A falling edge of `cs_n` gives a one-cycle `frame_start` and clears the bit counter and `byte_idx`. Partial bits from an earlier frame are discarded.
- R4: `si` is sampled on rising serial clock edges, MSB first. After the eighth bit, `rx_byte` holds the byte and `rx_valid` pulses for exactly one system clock.
- R5: `tx_byte` is captured in the cycle in which `rx_valid` is 1. Its MSB appears on `so_o` after the next falling serial clock edge, and each later falling edge presents the next lower bit. `so_oe` is 1 only while the block is selected, not paused, not dropped, and `tx_en` is 1.
- R6: Transfers decode identically whether the serial clock idles low (mode 0) or high (mode 3).
- R7: A pause starts only if `hold_n` falls while the serial clock is low. A fall while the clock is high leaves the transfer running.
- R8: While paused, serial clock edges neither advance the bit count nor shift output, `si` is ignored, and `so_oe` is 0. The interrupted byte completes correctly after release.
- R9: A pause ends only if `hold_n` rises while the serial clock is low. A rise while the clock is high keeps the pause.
- R10: A `drop` pulse while selected stops all byte strobes and forces `so_oe` to 0 until the next falling edge of `cs_n`.
- R11: A rising edge of `cs_n` gives a one-cycle `frame_end`. `frame_aligned` is 1 in that cycle exactly when no partial bits remain.
- R12: `byte_idx` counts the bytes completed in the current frame and saturates at its maximum (15 by default).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck | input | 1 | Serial clock from the master |
| cs_n | input | 1 | Active-low select |
| si | input | 1 | Serial data in |
| hold_n | input | 1 | Active-low pause request |
| so_o | output | 1 | Serial data out value |
| so_oe | output | 1 | Drive enable for the serial output |
| rx_byte | output | BYTE_W | Last completed byte |
| rx_valid | output | 1 | One-cycle byte strobe |
| byte_idx | output | CNT_W | Completed bytes in this frame, saturating |
| frame_start | output | 1 | Select fell |
| frame_end | output | 1 | Select rose |
| frame_aligned | output | 1 | Frame ended on a byte boundary (valid with frame_end) |
| tx_byte | input | BYTE_W | Byte to send in the next slot |
| tx_en | input | 1 | Output-enable request |
| drop | input | 1 | Silence the block until the next frame |

## Verification
The case of interest is the last serial clock rise of a byte and the rise of `cs_n` arriving together. In that case the byte strobe and the frame-end report land in the same system cycle, and the alignment flag must count the bit that completes in that same cycle. The bench provokes this by closing frames immediately after the final bit, and also after a random number of extra bits, in both clock polarities. It judges the result from the number of strobed bytes and from the alignment flag, which must be 1 only when no extra bits were sent. A second overlap occurs when a pause request and a serial clock transition arrive close together. The bench drives the request on both clock levels and judges it by whether `so_oe` drops and whether the interrupted byte still arrives intact.

// File: rtl/spi_hold_front.sv
module spi_hold_front #(
  parameter int BYTE_W = 8,
  parameter int SYNC_N = 2,
  parameter int CNT_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sck,
  input  logic              cs_n,
  input  logic              si,
  input  logic              hold_n,
  output logic              so_o,
  output logic              so_oe,
  output logic [BYTE_W-1:0] rx_byte,
  output logic              rx_valid,
  output logic [CNT_W-1:0]  byte_idx,
  output logic              frame_start,
  output logic              frame_end,
  output logic              frame_aligned,
  input  logic [BYTE_W-1:0] tx_byte,
  input  logic              tx_en,
  input  logic              drop
);
  localparam int BIT_W = $clog2(BYTE_W);
  localparam logic [BIT_W-1:0] LAST = BIT_W'(BYTE_W - 1);
  localparam logic [3:0] PIN_IDLE = 4'b1010;

  logic [SYNC_N-1:0][3:0] sy;
  logic [3:0] s;
  logic [2:0] q;
  logic sck_s, cs_s, si_s, hold_s;
  logic sck_rise, sck_fall, cs_fall, cs_rise, hold_fall, hold_rise;
  logic held, mute, live, run, take, last;
  logic [BIT_W-1:0]  bit_cnt, bit_nxt;
  logic [BYTE_W-2:0] rx_sh;
  logic [BYTE_W-1:0] tx_sh;
  logic so_r;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sy <= {SYNC_N{PIN_IDLE}};
      q  <= 3'b110;
    end else begin
      sy <= {sy[SYNC_N-2:0], {hold_n, si, cs_n, sck}};
      q  <= {hold_s, cs_s, sck_s};
    end

  assign s      = sy[SYNC_N-1];
  assign sck_s  = s[0];
  assign cs_s   = s[1];
  assign si_s   = s[2];
  assign hold_s = s[3];

  assign sck_rise  =  sck_s & ~q[0];
  assign sck_fall  = ~sck_s &  q[0];
  assign cs_fall   = ~cs_s  &  q[1];
  assign cs_rise   =  cs_s  & ~q[1];
  assign hold_fall = ~hold_s &  q[2];
  assign hold_rise =  hold_s & ~q[2];

  assign live = ~q[1];
  assign run  = live & ~held & ~mute;
  assign take = run & sck_rise;
  assign last = take & (bit_cnt == LAST);
  assign bit_nxt = !take ? bit_cnt : (last ? '0 : bit_cnt + 1'b1);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)
      held <= 1'b0;
    else if (cs_s)
      held <= 1'b0;
    else if (!held && hold_fall && !sck_s)
      held <= 1'b1;
    else if (held && hold_rise && !sck_s)
      held <= 1'b0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      bit_cnt  <= '0;
      byte_idx <= '0;
      rx_sh    <= '0;
      rx_byte  <= '0;
      rx_valid <= 1'b0;
      mute     <= 1'b0;
      tx_sh    <= '0;
      so_r     <= 1'b0;
    end else begin
      rx_valid <= last;
      if (cs_fall) begin
        bit_cnt  <= '0;
        byte_idx <= '0;
        mute     <= 1'b0;
        tx_sh    <= '0;
        so_r     <= 1'b0;
      end else begin
        bit_cnt <= bit_nxt;
        if (take) rx_sh <= {rx_sh[BYTE_W-3:0], si_s};
        if (last) begin
          rx_byte <= {rx_sh, si_s};
          if (byte_idx != '1) byte_idx <= byte_idx + 1'b1;
        end
        if (drop && live) mute <= 1'b1;
        if (rx_valid)
          tx_sh <= tx_byte;
        else if (run && sck_fall) begin
          so_r  <= tx_sh[BYTE_W-1];
          tx_sh <= {tx_sh[BYTE_W-2:0], 1'b0};
        end
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      frame_start   <= 1'b0;
      frame_end     <= 1'b0;
      frame_aligned <= 1'b0;
    end else begin
      frame_start   <= cs_fall;
      frame_end     <= cs_rise;
      frame_aligned <= cs_rise & (bit_nxt == '0);
    end

  assign so_o  = so_r;
  assign so_oe = ~cs_s & ~held & ~mute & tx_en;

  // R4
  rx_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

  // R4
  byte_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> bit_cnt == '0);

  // R3
  frame_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |-> (bit_cnt == '0 && byte_idx == '0 && !rx_valid));

  // R8
  hold_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (held && $past(held)) |-> ($stable(bit_cnt) && $stable(tx_sh)));

  // R10
  mute_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mute && $past(mute)) |-> !rx_valid);

  // R11
  aligned_with_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_aligned |-> frame_end);
endmodule

// File: tb/sim_spi_hold_front.sv
module sim_spi_hold_front;
  localparam int CLK_P = 10;
  localparam int HALF  = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sck = 1'b0, cs_n = 1'b1, si = 1'b0, hold_n = 1'b1;
  logic so_o, so_oe, rx_valid, frame_start, frame_end, frame_aligned;
  logic [7:0] rx_byte, tx_byte;
  logic [3:0] byte_idx;
  logic tx_en = 1'b1, drop = 1'b0;

  int n_chk = 0, n_bad = 0, fs_cnt = 0, fe_cnt = 0;
  logic last_al = 1'b0;
  bit done = 1'b0;
  logic [7:0] rxq[$];
  logic [7:0] fb [20];

  always #(CLK_P/2) clk = ~clk;

  assign tx_byte = rx_byte ^ 8'hA5;

  spi_hold_front u0 (
    .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .si(si), .hold_n(hold_n),
    .so_o(so_o), .so_oe(so_oe), .rx_byte(rx_byte), .rx_valid(rx_valid),
    .byte_idx(byte_idx), .frame_start(frame_start), .frame_end(frame_end),
    .frame_aligned(frame_aligned), .tx_byte(tx_byte), .tx_en(tx_en), .drop(drop)
  );

  initial forever begin
    @(negedge clk);
    if (rx_valid) rxq.push_back(rx_byte);
    if (frame_start) fs_cnt++;
    if (frame_end) begin fe_cnt++; last_al = frame_aligned; end
  end

  function automatic logic exp_bit(input logic [7:0] prev, input int i);
    logic [7:0] t;
    t = prev ^ 8'hA5;
    return t[i];
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic one_bit(input logic b, output logic o, output logic oe);
    @(negedge clk); sck = 1'b0; si = b;
    wait_clk(HALF);
    o = so_o; oe = so_oe;
    sck = 1'b1;
    wait_clk(HALF);
  endtask

  task automatic open_frame(input bit m3);
    @(negedge clk); sck = m3;
    wait_clk(4);
    cs_n = 1'b0;
    wait_clk(6);
  endtask

  task automatic close_frame(input bit m3);
    @(negedge clk); if (!m3) sck = 1'b0;
    wait_clk(HALF);
    cs_n = 1'b1;
    wait_clk(10);
  endtask

  task automatic run_frame(input bit m3, input int n, input int extra);
    logic o, oe;
    int fs0, fe0;
    fs0 = fs_cnt; fe0 = fe_cnt;
    rxq.delete();
    open_frame(m3);
    chk("R3 frame_start count", fs_cnt, fs0 + 1);
    for (int k = 0; k < n; k++)
      for (int i = 7; i >= 0; i--) begin
        one_bit(fb[k][i], o, oe);
        if (k > 0) begin
          chk(m3 ? "R5/R6 so_o mode3" : "R5 so_o mode0", o, exp_bit(fb[k-1], i));
          chk("R5 so_oe", oe, 1);
        end
      end
    for (int e = 0; e < extra; e++) one_bit(1'($urandom % 2), o, oe);
    wait_clk(4);
    chk("R12 byte_idx", byte_idx, (n > 15) ? 15 : n);
    close_frame(m3);
    chk(m3 ? "R4/R6 count mode3" : "R4 count mode0", rxq.size(), n);
    for (int k = 0; k < n && k < rxq.size(); k++)
      chk(m3 ? "R4/R6 byte mode3" : "R4 byte mode0", rxq[k], fb[k]);
    chk("R11 frame_end count", fe_cnt, fe0 + 1);
    chk("R11 aligned", last_al, (extra == 0) ? 1 : 0);
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic o, oe;
    int dummy;
    dummy = $urandom(32'd4242);
    wait_clk(3);
    chk("R1 so_oe", so_oe, 0);
    chk("R1 rx_valid", rx_valid, 0);
    chk("R1 byte_idx", byte_idx, 0);
    chk("R1 frame pulses", {frame_start, frame_end}, 0);
    rst_n = 1'b1;
    wait_clk(6);
    chk("R2 so_oe idle", so_oe, 0);

    // R2: deselected clocking
    rxq.delete();
    for (int i = 0; i < 16; i++) begin
      @(negedge clk); sck = ~sck; si = 1'($urandom % 2);
      wait_clk(HALF);
      if (so_oe) chk("R2 so_oe while deselected", so_oe, 0);
    end
    sck = 1'b0; wait_clk(6);
    chk("R2 no strobe", rxq.size(), 0);
    chk("R2 so_oe", so_oe, 0);
    chk("R2 no frame", fs_cnt + fe_cnt, 0);

    // directed: aligned and partial frames, both modes
    fb[0] = 8'h80; fb[1] = 8'h01; fb[2] = 8'hFF;
    run_frame(1'b0, 3, 0);
    run_frame(1'b1, 3, 0);
    run_frame(1'b0, 2, 5);
    fb[0] = 8'h6D;
    run_frame(1'b1, 1, 0); // R3: prior partial bits discarded

    // R12: saturation
    for (int k = 0; k < 17; k++) fb[k] = 8'(k * 29 + 3);
    run_frame(1'b0, 17, 0);

    // R7, R8, R9: pause scenarios
    rxq.delete();
    open_frame(1'b0);
    for (int i = 7; i >= 0; i--) one_bit(fb[0][i], o, oe);
    fb[0] = 8'h5A; fb[1] = 8'hC3; fb[2] = 8'h96;
    rxq.delete();
    close_frame(1'b0);
    open_frame(1'b0);
    for (int i = 7; i >= 0; i--) one_bit(fb[0][i], o, oe);
    for (int i = 7; i >= 5; i--) one_bit(fb[1][i], o, oe);
    @(negedge clk); hold_n = 1'b0;          // sck high: must not pause
    wait_clk(6); sck = 1'b0; wait_clk(6);
    chk("R7 not paused on high sck", so_oe, 1);
    hold_n = 1'b1; wait_clk(6);
    for (int i = 4; i >= 0; i--) begin
      one_bit(fb[1][i], o, oe);
      chk("R7 so_o continues", o, exp_bit(fb[0], i));
    end
    for (int i = 7; i >= 4; i--) one_bit(fb[2][i], o, oe);
    @(negedge clk); sck = 1'b0; wait_clk(6);
    hold_n = 1'b0; wait_clk(6);
    chk("R8 so_oe paused", so_oe, 0);
    for (int t = 0; t < 3; t++) begin
      sck = 1'b1; si = 1'($urandom % 2); wait_clk(HALF);
      sck = 1'b0; wait_clk(HALF);
    end
    sck = 1'b1; wait_clk(HALF);
    hold_n = 1'b1; wait_clk(6);              // sck high: must stay paused
    chk("R9 stays paused", so_oe, 0);
    sck = 1'b0; wait_clk(HALF);
    sck = 1'b1; wait_clk(HALF);
    sck = 1'b0; wait_clk(HALF);
    hold_n = 1'b0; wait_clk(6);
    hold_n = 1'b1; wait_clk(6);
    chk("R9 released on low sck", so_oe, 1);
    for (int i = 3; i >= 0; i--) begin
      one_bit(fb[2][i], o, oe);
      chk("R8 so_o after pause", o, exp_bit(fb[1], i));
    end
    close_frame(1'b0);
    chk("R8 byte count", rxq.size(), 3);
    for (int k = 0; k < 3 && k < rxq.size(); k++) chk("R8 bytes intact", rxq[k], fb[k]);
    chk("R11 aligned after pause", last_al, 1);

    // R10: drop
    rxq.delete();
    open_frame(1'b1);
    for (int i = 7; i >= 0; i--) one_bit(1'(8'h11 >> i), o, oe);
    wait_clk(4);
    drop = 1'b1; @(negedge clk); drop = 1'b0;
    wait_clk(3);
    for (int k = 0; k < 2; k++)
      for (int i = 7; i >= 0; i--) begin
        one_bit(1'($urandom % 2), o, oe);
        if (oe) chk("R10 so_oe muted", oe, 0);
      end
    chk("R10 so_oe muted end", so_oe, 0);
    close_frame(1'b1);
    chk("R10 only first byte", rxq.size(), 1);
    fb[0] = 8'h3C; fb[1] = 8'hE7;
    run_frame(1'b0, 2, 0);                    // R10: cleared by new frame

    // random frames
    for (int f = 0; f < 40; f++) begin
      int n, extra;
      bit m3;
      n = 1 + int'($urandom % 5);
      m3 = 1'($urandom % 2);
      extra = ($urandom % 4 == 0) ? 1 + int'($urandom % 7) : 0;
      for (int k = 0; k < n; k++) fb[k] = 8'($urandom);
      run_frame(m3, n, extra);
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule